// File: doc/BRIEF.md
# Maskable Sticky Interrupt Status Register

This block collects single-cycle hardware event pulses into a vector of sticky status bits. Each bit is paired with a mask bit, and the AND of the two drives one line of the interrupt output vector. Software reaches the block over a simple request/acknowledge register bus with byte enables.

Software acknowledges an interrupt by writing ones to the status address, which clears those bits. It can raise interrupts for test or for signalling by writing ones to a separate set address. A hardware event that lands in the same cycle as a clear of the same bit is never lost. A bus access takes two cycles. The acknowledge and the registered read data appear in the second cycle, and writes take effect at the end of that same cycle. Edge detection and input synchronisation are done upstream, so the event input is taken to be already clean and synchronous.

Top module: `irq_status_unit`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), the status vector, the mask, ack_o, rdata_o and irq_o are all zero.
- R2: When cs_i is high and ack_o is low at a clock edge, ack_o is high for the following cycle. In the cycle after an ack, ack_o is low again.
- R3: The read data is registered at the edge that raises ack_o. Offset 0 (status) and offset 1 (set alias) both return the current status vector, and offset 2 returns the mask.
- R4: Any other offset reads as zero and still completes with a normal acknowledge.
- R5: A high bit on evt_i sets the matching status bit at the next edge, in every cycle, whether or not a bus access is in progress. The bit then stays set until software clears it.
- R6: A committed write to offset 0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R7: A committed write to offset 1 sets each status bit whose write-data bit is 1. A 0 in the write data has no effect.
- R8: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A write is committed only at the edge where cs_i, wr_i and ack_o are all high. In the first cycle of the access, nothing changes.
- R10: Byte enable bit k gates the write for data bits 8k+7 down to 8k. This applies to clear, set and mask writes alike.
- R11: The mask at offset 2 is a byte-enabled read/write register. It resets to zero, so every interrupt is masked after reset.
- R12: Each bit of irq_o equals the matching status bit AND the matching mask bit, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus request (chip select) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register offset |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Byte enables, one per data byte lane |
| evt_i | input | DW | Hardware event pulses, one per status bit |
| rdata_o | output | DW | Registered read data |
| ack_o | output | 1 | Bus acknowledge |
| irq_o | output | DW | Masked interrupt vector |

## Verification
The critical overlap is a hardware event on a bit in the same cycle that a software clear of that bit commits. The bench provokes it by driving the event in the second, acknowledging cycle of a clear write, and it expects the bit to survive. The opposite case drives the event only in the first cycle of the clear access. That event is captured first and then removed by the commit, which shows both that events are taken during bus traffic and that writes land only in the ack cycle. A random phase keeps sparse events going under mixed clear, set and mask writes, with random byte enables. Every read result and every value on irq_o is compared against the bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_SET  = 1;
  localparam int unsigned OFF_MASK = 2;

  typedef enum logic [1:0] {
    SEL_STAT,
    SEL_SET,
    SEL_MASK,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irq_bus_slave.sv
module irq_bus_slave #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [DW-1:0] rd_val_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else if (cs_i && !ack_o) begin
      ack_o   <= 1'b1;
      rdata_o <= rd_val_i;
    end else begin
      ack_o   <= 1'b0;
    end
  end

  assert_ack_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !ack_o) |=> ack_o);
  assert_ack_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] stat_o
);
  // events and sets override a clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | evt_i | set_i;
  end

  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> (($past(stat_o) & ~stat_o) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] we_bits_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o & ~we_bits_i) | (wdata_i & we_bits_i);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   evt_i,
  output logic [DW-1:0]   rdata_o,
  output logic            ack_o,
  output logic [DW-1:0]   irq_o
);
  localparam int NB = DW / 8;

  reg_sel_e      sel;
  logic          commit;
  logic [DW-1:0] lane_bits;
  logic [DW-1:0] clr_vec, set_vec, mask_we;
  logic [DW-1:0] stat_q, mask_q, rd_val;

  always_comb begin
    if      (addr_i == AW'(OFF_STAT)) sel = SEL_STAT;
    else if (addr_i == AW'(OFF_SET))  sel = SEL_SET;
    else if (addr_i == AW'(OFF_MASK)) sel = SEL_MASK;
    else                              sel = SEL_NONE;
  end

  generate
    for (genvar k = 0; k < NB; k++) begin : g_lane
      assign lane_bits[8*k +: 8] = {8{be_i[k]}};
    end
  endgenerate

  // writes land only in the acknowledge cycle
  assign commit  = cs_i & wr_i & ack_o;
  assign clr_vec = (commit && sel == SEL_STAT) ? (wdata_i & lane_bits) : '0;
  assign set_vec = (commit && sel == SEL_SET)  ? (wdata_i & lane_bits) : '0;
  assign mask_we = (commit && sel == SEL_MASK) ? lane_bits : '0;

  irq_stat_reg #(.DW(DW)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_vec),
    .set_i  (set_vec),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.DW(DW)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_bits_i (mask_we),
    .wdata_i   (wdata_i),
    .mask_o    (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT, SEL_SET: rd_val = stat_q;
      SEL_MASK:          rd_val = mask_q;
      default:           rd_val = '0;
    endcase
  end

  irq_bus_slave #(.DW(DW)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .rd_val_i (rd_val),
    .ack_o    (ack_o),
    .rdata_o  (rdata_o)
  );

  assign irq_o = stat_q & mask_q;

  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i && ack_o && sel == SEL_MASK) |=> $stable(mask_q));
  assert_unmapped_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !ack_o && sel == SEL_NONE) |=> (ack_o && rdata_o == '0));
  assert_irq_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (irq_o == '0));
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NB = DW / 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cs_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [DW-1:0]   wdata_i = '0;
  logic [NB-1:0]   be_i = '0;
  logic [DW-1:0]   evt_i = '0;
  logic [DW-1:0]   rdata_o, irq_o;
  logic            ack_o;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_stat = '0, m_mask = '0;

  always #10 clk = ~clk;

  irq_status_unit #(.DW(DW), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .evt_i(evt_i),
    .rdata_o(rdata_o), .ack_o(ack_o), .irq_o(irq_o)
  );

  function automatic logic [DW-1:0] lanes(input logic [NB-1:0] be);
    logic [DW-1:0] r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = {8{be[k]}};
    return r;
  endfunction

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    if (a == 0 || a == 1) return m_stat;
    if (a == 2) return m_mask;
    return '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge of the model: clear first, then events and sets win
  task automatic apply(input logic [DW-1:0] evt, input logic cm, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be);
    logic [DW-1:0] clr, st, bm;
    bm = lanes(be);
    clr = (cm && w && a == 0) ? (d & bm) : '0;
    st  = (cm && w && a == 1) ? (d & bm) : '0;
    if (cm && w && a == 2) m_mask = (m_mask & ~bm) | (d & bm);
    m_stat = (m_stat & ~clr) | evt | st;
  endtask

  task automatic idle(input logic [DW-1:0] evt);
    @(negedge clk); evt_i = evt;
    @(posedge clk); #1 apply(evt, 1'b0, 1'b0, '0, '0, '0);
    @(negedge clk); evt_i = '0;
    check("R12 irq", irq_o, m_stat & m_mask);
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] be, input logic [DW-1:0] ea, input logic [DW-1:0] eb,
                      output logic [DW-1:0] rd);
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    cs_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d; be_i = be; evt_i = ea;
    exp_rd = rd_model(a);
    @(posedge clk); #1 apply(ea, 1'b0, w, a, d, be);  // R9: first cycle never commits
    @(negedge clk);
    check("R2 ack high", {31'b0, ack_o}, 32'd1);
    check((a > 2) ? "R4 read" : "R3 read", rdata_o, exp_rd);
    check("R12 irq", irq_o, m_stat & m_mask);
    rd = rdata_o;
    evt_i = eb;
    @(posedge clk); #1 apply(eb, 1'b1, w, a, d, be);
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; evt_i = '0;
    check("R2 ack low", {31'b0, ack_o}, 32'd0);
    check("R12 irq", irq_o, m_stat & m_mask);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'd2024));
    #35;
    check("R1 ack reset", {31'b0, ack_o}, 32'd0);
    check("R1 rdata reset", rdata_o, '0);
    check("R1 irq reset", irq_o, '0);
    rst_ni = 1'b1;
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R1 status reset", rd, '0);
    xfer(1'b0, 4'd2, '0, '1, '0, '0, rd); check("R11 mask reset", rd, '0);

    idle(32'h0000_0011);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R5 capture", rd, 32'h0000_0011);
    idle('0);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R5 sticky", rd, 32'h0000_0011);
    xfer(1'b1, 4'd0, 32'h0000_0001, 4'hF, '0, '0, rd);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R6 clear", rd, 32'h0000_0010);
    xfer(1'b1, 4'd1, 32'h8000_0100, 4'b1000, '0, '0, rd);
    xfer(1'b0, 4'd1, '0, '1, '0, '0, rd); check("R7 R10 set lane", rd, 32'h8000_0010);
    xfer(1'b1, 4'd2, 32'hFFFF_FFFF, 4'b0011, '0, '0, rd);
    xfer(1'b0, 4'd2, '0, '1, '0, '0, rd); check("R11 R10 mask", rd, 32'h0000_FFFF);
    check("R12 masked irq", irq_o, 32'h0000_0010);
    xfer(1'b1, 4'd0, 32'h0000_0010, 4'hF, '0, 32'h0000_0010, rd);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R8 event beats clear", rd, 32'h8000_0010);
    xfer(1'b1, 4'd0, 32'h0000_0002, 4'hF, 32'h0000_0002, '0, rd);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R9 commit in ack cycle", rd, 32'h8000_0010);
    xfer(1'b1, 4'd0, 32'h8000_0000, 4'b0111, '0, '0, rd);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R10 lane gated clear", rd, 32'h8000_0010);
    xfer(1'b0, 4'd9, '0, '1, '0, '0, rd); check("R4 unmapped", rd, '0);
    xfer(1'b1, 4'd0, 32'hFFFF_FFFF, 4'hF, '0, '0, rd);
    xfer(1'b0, 4'd0, '0, '1, '0, '0, rd); check("R6 clear all", rd, '0);

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] ea, eb;
      a  = AW'($urandom % 5);
      ea = $urandom & $urandom & $urandom;
      eb = $urandom & $urandom & $urandom;
      if ($urandom % 4 == 0) idle(ea);
      else xfer(1'($urandom), a, $urandom, NB'($urandom), ea, eb, rd);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule